// File: doc/BRIEF.md
# Fixed Off-Time Bridge Current Chopper

This block is the digital half of a current regulator for one H-bridge made of four switches: a high-side and a low-side switch on each of two legs, A and B. When enabled, it turns on one diagonal pair of switches, chosen by the polarity input, and drives the winding until an external current comparator reports that the trip level has been reached. It ignores the comparator for a programmable blanking window after each turn-on, so switching noise cannot end a drive phase early.

A trip starts a fixed off-time, counted in clock cycles. The decay-mode input is sampled at the trip. In slow mode, both low-side switches conduct for the whole off-time. In mixed mode, the opposite diagonal conducts for 5/16 of the off-time (fast decay), and slow decay follows for the rest. Because the switches stay on during recirculation, current flows through them rather than through their body diodes. Every change of the switch pattern passes through a dead interval. In that interval, only the switches common to the old and new patterns stay on. A fault or a low enable turns every switch off at once.

Top module: `chop_ctrl`

## Requirements
- R1: While reset is asserted, and after reset while enable is low, all four gate outputs are 0.
- R2: Gate vector {hs_a, ls_a, hs_b, ls_b}: the drive pattern is 1001 when pol_i=1 and 0110 when pol_i=0. Drive starts DEAD_CYC+1 cycles after enable rises, with the first DEAD_CYC of those cycles all off.
- R3: After every entry into drive, trip_i is ignored on the BLANK_CYC rising edges that follow. A trip high on the next edge is accepted. This also holds on re-entry after an off-time.
- R4: With mixed_i=0 at the trip, the bridge runs in slow decay (pattern 0101, both low sides). Drive returns OFF_CYC+DEAD_CYC cycles after the trip edge.
- R5: With mixed_i=1 at the trip, the bridge runs in fast decay (0110 for pol 1, 1001 for pol 0) until FAST=OFF_CYC*5/16 cycles after the trip edge. It then passes through dead time into slow decay (0101) until OFF_CYC cycles after the trip.
- R6: Every pattern change holds the intersection of the old and new patterns for exactly DEAD_CYC cycles before the new pattern appears. No switch turns on in the cycle after its same-leg partner was on.
- R7: The high-side and low-side switches of one leg are never on together.
- R8: fault_i=1 or en_i=0 forces all four gates to 0 on the next edge, in any phase. After the condition clears, the block restarts with DEAD_CYC all-off cycles and then drives.
- R9: pol_i is sampled only when a new drive phase is commanded. A change during drive or decay does not alter the present pattern or the decay patterns.
- R10: mixed_i is sampled only at the accepted trip. A change during the off-time has no effect on the running decay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1 lets the bridge switch; 0 forces all off |
| fault_i | input | 1 | Overtemperature or undervoltage; 1 forces all off |
| trip_i | input | 1 | Current comparator output, 1 = trip level reached |
| mixed_i | input | 1 | Decay select sampled at trip: 0 slow, 1 mixed |
| pol_i | input | 1 | Current direction sampled at each drive start |
| hs_a_o | output | 1 | Leg A high-side gate |
| ls_a_o | output | 1 | Leg A low-side gate |
| hs_b_o | output | 1 | Leg B high-side gate |
| ls_b_o | output | 1 | Leg B low-side gate |

## Verification
The off-time is traced cycle by cycle for slow and mixed decay under both polarities. These traces show whether the fast portion, the slow portion and each dead interval have the correct length, and whether the switches shared between patterns stay on. A comparator held high through a whole off-time shows that blanking is re-armed on re-entry and is not just a one-time delay after enable. Polarity and mode inputs are changed in the middle of a phase; the later patterns show whether they were sampled at the right moment. A fault during drive and a disable during decay show that the shutdown is immediate and that the restart passes through dead time.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DEAD  = 3'd1,
        PH_DRIVE = 3'd2,
        PH_FAST  = 3'd3,
        PH_SLOW  = 3'd4
    } phase_e;

    // bit positions inside the four-switch gate vector
    localparam int G_HA = 3;
    localparam int G_LA = 2;
    localparam int G_HB = 1;
    localparam int G_LB = 0;

endpackage

// File: rtl/chop_cnt.sv
module chop_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (dec_i && cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/chop_pattern.sv
module chop_pattern
    import chop_pkg::*;
(
    input  phase_e     ph_i,
    input  logic       pol_i,
    output logic [3:0] gate_o
);
    always_comb begin
        gate_o = '0;
        case (ph_i)
            PH_DRIVE: begin
                gate_o[pol_i ? G_HA : G_HB] = 1'b1;
                gate_o[pol_i ? G_LB : G_LA] = 1'b1;
            end
            PH_FAST: begin
                gate_o[pol_i ? G_HB : G_HA] = 1'b1;
                gate_o[pol_i ? G_LA : G_LB] = 1'b1;
            end
            PH_SLOW: begin
                gate_o[G_LA] = 1'b1;
                gate_o[G_LB] = 1'b1;
            end
            default: gate_o = '0;
        endcase
    end
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 6000,
    parameter int BLANK_CYC = 200,
    parameter int DEAD_CYC  = 95
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fault_i,
    input  logic trip_i,
    input  logic mixed_i,
    input  logic pol_i,
    output logic hs_a_o,
    output logic ls_a_o,
    output logic hs_b_o,
    output logic ls_b_o
);
    localparam int FAST_CYC = (OFF_CYC * 5) / 16;
    localparam int OFF_W    = $clog2(OFF_CYC + 2);
    localparam int BLK_W    = $clog2(BLANK_CYC + 2);
    localparam int DT_W     = $clog2(DEAD_CYC + 2);
    localparam logic [OFF_W-1:0] SLOW_MARK = OFF_W'(OFF_CYC - FAST_CYC);

    typedef struct packed {
        phase_e          ph;
        phase_e          nxt;
        logic [DT_W-1:0] dcnt;
        logic [3:0]      gate;
        logic            pol;
    } ctl_t;

    ctl_t q, d;

    logic             abort;
    logic             go;
    phase_e           tgt_ph;
    logic             tgt_pol;
    logic [3:0]       tgt_gate;
    logic             off_ld, blk_ld, off_run;
    logic [OFF_W-1:0] off_cnt;
    logic [BLK_W-1:0] blk_cnt;

    assign abort   = !en_i || fault_i;
    assign off_run = (q.ph == PH_DEAD) || (q.ph == PH_FAST) || (q.ph == PH_SLOW);

    chop_cnt #(.W(OFF_W)) u_off (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (off_ld),
        .val_i  (OFF_W'(OFF_CYC - 1)),
        .dec_i  (off_run),
        .cnt_o  (off_cnt)
    );

    chop_cnt #(.W(BLK_W)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (blk_ld),
        .val_i  (BLK_W'(BLANK_CYC)),
        .dec_i  (q.ph == PH_DRIVE),
        .cnt_o  (blk_cnt)
    );

    // which pattern comes next, and whether a change is requested
    always_comb begin
        go      = 1'b0;
        tgt_ph  = PH_DRIVE;
        tgt_pol = q.pol;
        case (q.ph)
            PH_IDLE: begin
                go      = 1'b1;
                tgt_pol = pol_i;
            end
            PH_DEAD: tgt_ph = q.nxt;
            PH_DRIVE: begin
                go     = trip_i && (blk_cnt == '0);
                tgt_ph = mixed_i ? PH_FAST : PH_SLOW;
            end
            PH_FAST: begin
                if (off_cnt == '0) begin
                    go      = 1'b1;
                    tgt_pol = pol_i;
                end else if (off_cnt == SLOW_MARK) begin
                    go     = 1'b1;
                    tgt_ph = PH_SLOW;
                end
            end
            PH_SLOW: begin
                go      = (off_cnt == '0);
                tgt_pol = pol_i;
            end
            default: go = 1'b0;
        endcase
    end

    chop_pattern u_pat (
        .ph_i   (tgt_ph),
        .pol_i  (tgt_pol),
        .gate_o (tgt_gate)
    );

    always_comb begin
        d      = q;
        off_ld = 1'b0;
        blk_ld = 1'b0;
        if (abort) begin
            d.ph   = PH_IDLE;
            d.gate = '0;
        end else if (q.ph == PH_DEAD) begin
            if (q.dcnt == '0) begin
                d.ph   = q.nxt;
                d.gate = tgt_gate;
                blk_ld = (q.nxt == PH_DRIVE);
            end else begin
                d.dcnt = q.dcnt - DT_W'(1);
            end
        end else if (go) begin
            d.ph   = PH_DEAD;
            d.nxt  = tgt_ph;
            d.dcnt = DT_W'(DEAD_CYC - 1);
            d.gate = q.gate & tgt_gate;
            d.pol  = tgt_pol;
            off_ld = (q.ph == PH_DRIVE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph   <= PH_IDLE;
            q.nxt  <= PH_IDLE;
            q.dcnt <= '0;
            q.gate <= '0;
            q.pol  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hs_a_o = q.gate[G_HA];
    assign ls_a_o = q.gate[G_LA];
    assign hs_b_o = q.gate[G_HB];
    assign ls_b_o = q.gate[G_LB];

    // leg exclusivity
    p_leg_a_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a_o && ls_a_o));
    p_leg_b_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_b_o && ls_b_o));

    // a switch only turns on after its partner was off
    p_gap_ha_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_a_o) |-> $past(!ls_a_o));
    p_gap_la_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_a_o) |-> $past(!hs_a_o));
    p_gap_hb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_b_o) |-> $past(!ls_b_o));
    p_gap_lb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_b_o) |-> $past(!hs_b_o));

    // shutdown on fault or disable
    p_abort_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i || !en_i) |=> (!hs_a_o && !ls_a_o && !hs_b_o && !ls_b_o));

    // blanking armed at every drive entry and holds drive while running
    p_blank_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_DRIVE && $past(q.ph) != PH_DRIVE) |-> blk_cnt == BLK_W'(BLANK_CYC));
    p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_DRIVE && blk_cnt != '0 && !abort) |=> q.ph == PH_DRIVE);

    // slow decay never uses a high side
    p_slow_low_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_SLOW) |-> (!hs_a_o && !hs_b_o && ls_a_o && ls_b_o));

endmodule

// File: tb/chop_ctrl_test.sv
`timescale 1ns/1ps
module chop_ctrl_test;
    localparam int OFF  = 32;
    localparam int BLK  = 4;
    localparam int DT   = 2;
    localparam int FAST = (OFF * 5) / 16;
    localparam logic [3:0] SLW = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, fault = 1'b0, trip = 1'b0, mixed = 1'b0, pol = 1'b1;
    logic ha, la, hb, lb;
    logic [3:0] g;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chop_ctrl #(.OFF_CYC(OFF), .BLANK_CYC(BLK), .DEAD_CYC(DT)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .fault_i(fault), .trip_i(trip),
        .mixed_i(mixed), .pol_i(pol),
        .hs_a_o(ha), .ls_a_o(la), .hs_b_o(hb), .ls_b_o(lb)
    );

    assign g = {ha, la, hb, lb};

    function automatic logic [3:0] drv(input logic p);
        return p ? 4'b1001 : 4'b0110;
    endfunction
    function automatic logic [3:0] fst(input logic p);
        return p ? 4'b0110 : 4'b1001;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic [3:0] exp, input string req, input string what);
        n_run++;
        if (g !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, g, exp);
        end
        n_run++;
        if ((g[3] && g[2]) || (g[1] && g[0])) begin
            n_fail++;
            $display("FAIL R7 %s: got %b expected no leg with both switches on", what, g);
        end
    endtask

    // enable from idle; returns right after drive entry (blanking armed)
    task automatic enter_drive(input logic p, input string req);
        en = 1'b0;
        step();
        pol = p;
        en = 1'b1;
        for (int i = 1; i <= DT; i++) begin
            step();
            check(4'b0000, "R6", "dead before first drive");
        end
        step();
        check(drv(p), req, "drive pattern");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        check(4'b0000, "R1", "during reset");
        rst_n = 1'b1;
        repeat (3) step();
        check(4'b0000, "R1", "after reset, disabled");
    endtask

    task automatic t_drive_pol();
        enter_drive(1'b1, "R2");
        enter_drive(1'b0, "R2");
    endtask

    // k counts edges after the accepted trip edge
    function automatic logic [3:0] exp_off(input int k, input logic m, input logic p, input logic pn);
        if (!m) begin
            if (k < DT)       return drv(p) & SLW;
            if (k < OFF)      return SLW;
            if (k < OFF + DT) return SLW & drv(pn);
            return drv(pn);
        end
        if (k < DT)        return drv(p) & fst(p);
        if (k < FAST)      return fst(p);
        if (k < FAST + DT) return fst(p) & SLW;
        if (k < OFF)       return SLW;
        if (k < OFF + DT)  return SLW & drv(pn);
        return drv(pn);
    endfunction

    task automatic t_off(input logic m, input logic p, input logic pn, input logic m_after,
                         input string req);
        enter_drive(p, "R2");
        repeat (BLK) step();
        trip = 1'b1;
        mixed = m;
        @(posedge clk);
        @(negedge clk);
        trip = 1'b0;
        mixed = m_after;  // R10: no effect after the trip
        pol = pn;         // R9: only the next drive sees it
        check(exp_off(0, m, p, pn), req, "off-time k=0");
        for (int k = 1; k <= OFF + DT; k++) begin
            step();
            check(exp_off(k, m, p, pn), req, $sformatf("off-time k=%0d", k));
        end
    endtask

    task automatic t_blank();
        mixed = 1'b0;
        enter_drive(1'b1, "R2");
        trip = 1'b1;
        for (int i = 1; i <= BLK; i++) begin
            step();
            check(drv(1'b1), "R3", "trip ignored while blanked");
        end
        step();
        check(drv(1'b1) & SLW, "R3", "trip accepted after blanking");
        for (int k = 1; k <= OFF + DT; k++) step();
        check(drv(1'b1), "R3", "drive re-entered with trip still high");
        for (int i = 1; i <= BLK; i++) begin
            step();
            check(drv(1'b1), "R3", "re-entry blanking");
        end
        step();
        check(drv(1'b1) & SLW, "R3", "trip accepted after re-entry blanking");
        trip = 1'b0;
    endtask

    task automatic t_fault();
        enter_drive(1'b1, "R2");
        repeat (BLK + 1) step();
        fault = 1'b1;
        step();
        check(4'b0000, "R8", "fault turns all off");
        repeat (3) step();
        check(4'b0000, "R8", "fault held");
        fault = 1'b0;
        for (int i = 1; i <= DT; i++) begin
            step();
            check(4'b0000, "R8", "restart dead time after fault");
        end
        step();
        check(drv(1'b1), "R8", "drive after fault clears");
        // disable in the middle of a mixed decay
        repeat (BLK) step();
        trip = 1'b1;
        mixed = 1'b1;
        step();
        trip = 1'b0;
        repeat (DT + 2) step();
        check(fst(1'b1), "R5", "fast decay before disable");
        en = 1'b0;
        step();
        check(4'b0000, "R8", "disable during decay");
        en = 1'b1;
        for (int i = 1; i <= DT; i++) begin
            step();
            check(4'b0000, "R8", "dead after re-enable");
        end
        step();
        check(drv(1'b1), "R8", "drive after re-enable");
    endtask

    initial begin
        t_reset();
        t_drive_pol();
        t_blank();
        t_off(1'b0, 1'b1, 1'b1, 1'b1, "R4");
        t_off(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        t_off(1'b1, 1'b1, 1'b1, 1'b1, "R5");
        t_off(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        t_off(1'b1, 1'b1, 1'b0, 1'b0, "R9");
        t_off(1'b0, 1'b0, 1'b1, 1'b1, "R10");
        t_fault();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule